// File: doc/BRIEF.md
# UART Line and Modem Control

This block keeps the line control and modem control registers of a 16550-style serial port and turns them into pin-level behaviour. The CPU writes and reads the two registers through a small address/data port. The block sits between the transmitter, the receiver and the package pins. It drives the serial output pin, drives the four active-low modem control outputs and passes the active-low modem status inputs inward as active-high status bits. It also gives the address decoder a select that swaps the normal registers for the divisor latch and the extended registers.

Two controls change the signal paths. The break control forces the serial output pin low. The loopback control connects the transmitter output to the receiver input inside the block. In loopback it also feeds the modem control register bits back as modem status and holds every output pin at its idle level. A four-state line-mode machine tracks these two controls. Its states are `LM_NORMAL`, `LM_BREAK`, `LM_LOOP` and `LM_LOOP_BRK`. A line control write moves between the break and no-break variant of the current state (NORMAL<->BREAK, LOOP<->LOOP_BRK). A modem control write moves between the loopback and non-loopback variant (NORMAL<->LOOP, BREAK<->LOOP_BRK). A write that changes nothing keeps the state. Reset enters `LM_NORMAL`.

Top module: `uart_line_ctrl`

## Requirements
- R1: After reset both registers read 0, `tx_pin` follows `tx_serial_in`, `div_access` is 0 and all four modem output pins are 1.
- R2: With line control bit 6 set and loopback off, `tx_pin` is 0 whatever `tx_serial_in` does. Clearing the bit restores `tx_pin` = `tx_serial_in`.
- R3: `div_access` equals line control bit 7 from the cycle after the write.
- R4: With loopback off, modem control bits 0, 1, 2 and 3 drive `dtr_n`, `rts_n`, `op1_n` and `op2_n` respectively, each inverted (bit 1 gives pin 0).
- R5: Modem control bits 7:5 always read back 0. Bits 4:0 read back as written.
- R6: With modem control bit 4 set, `tx_pin` is 1, `rx_to_rcv` equals `tx_serial_in` and `rx_pin` has no effect on `rx_to_rcv`.
- R7: In loopback the four modem output pins are 1 and the modem status pins are ignored. The status outputs come from the register: `cts_st` = bit 1, `dsr_st` = bit 0, `ri_st` = bit 2, `dcd_st` = bit 3.
- R8: In loopback, setting the break bit changes neither `tx_pin` (stays 1) nor `rx_to_rcv` (still `tx_serial_in`).
- R9: With loopback off, `rx_to_rcv` = `rx_pin` and each status output is the inverse of its pin (`cts_st` = !`cts_n`, and likewise for the others).
- R10: Line control reads back all 8 bits as written. The line control register is at address 3 and the modem control register at address 4. Any other address reads 0, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| tx_serial_in | input | 1 | Serial output of the transmitter |
| rx_pin | input | 1 | Serial input pin |
| tx_pin | output | 1 | Serial output pin |
| rx_to_rcv | output | 1 | Serial input delivered to the receiver |
| div_access | output | 1 | Divisor-latch access select for the decoder |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| op1_n | output | 1 | User output 1, active low |
| op2_n | output | 1 | User output 2, active low |
| cts_n | input | 1 | Clear to send pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| cts_st | output | 1 | Clear to send status, active high |
| dsr_st | output | 1 | Data set ready status, active high |
| ri_st | output | 1 | Ring indicator status, active high |
| dcd_st | output | 1 | Carrier detect status, active high |

## Verification
The hardest state to reach is `LM_LOOP_BRK`. It needs break and loopback set together, and those two controls live in different registers. The bench sets break first and then turns loopback on. It toggles `tx_serial_in` and `rx_pin` in opposite directions, so that a break leak or a pin leak shows up at `tx_pin` or `rx_to_rcv`. The bench then leaves the state through the other register, clearing loopback first. This checks that break is then visible on `tx_pin`.

// File: rtl/ucl_pkg.sv
package ucl_pkg;
    typedef enum logic [1:0] {
        LM_NORMAL   = 2'd0,
        LM_BREAK    = 2'd1,
        LM_LOOP     = 2'd2,
        LM_LOOP_BRK = 2'd3
    } line_mode_e;

    localparam int BRK_BIT  = 6;
    localparam int DIV_BIT  = 7;
    localparam int DTR_BIT  = 0;
    localparam int RTS_BIT  = 1;
    localparam int OP1_BIT  = 2;
    localparam int OP2_BIT  = 3;
    localparam int LOOP_BIT = 4;
    localparam int MCR_USED = 5;
endpackage

// File: rtl/ucl_regs.sv
module ucl_regs #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int LCR_ADDR = 3,
    parameter int MCR_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] lcr_q,
    output logic [DATA_W-1:0] mcr_q,
    output logic              lcr_wr,
    output logic              mcr_wr
);
    import ucl_pkg::*;

    localparam logic [DATA_W-1:0] MCR_MASK = DATA_W'((1 << MCR_USED) - 1);

    assign lcr_wr = wr_en && (addr == ADDR_W'(LCR_ADDR));
    assign mcr_wr = wr_en && (addr == ADDR_W'(MCR_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q <= '0;
            mcr_q <= '0;
        end else begin
            if (lcr_wr) lcr_q <= wdata;
            if (mcr_wr) mcr_q <= wdata & MCR_MASK;
        end
    end

    always_comb begin
        if (addr == ADDR_W'(LCR_ADDR))      rd_data = lcr_q;
        else if (addr == ADDR_W'(MCR_ADDR)) rd_data = mcr_q;
        else                                rd_data = '0;
    end

    // R5
    mcr_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_q[DATA_W-1:MCR_USED] == '0);

    // R10
    lcr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lcr_wr |=> $stable(lcr_q));
endmodule

// File: rtl/ucl_mode_fsm.sv
module ucl_mode_fsm (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lcr_wr,
    input  logic                  mcr_wr,
    input  logic                  brk_bit,
    input  logic                  loop_bit,
    output ucl_pkg::line_mode_e   mode
);
    import ucl_pkg::*;

    line_mode_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LM_NORMAL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LM_NORMAL: begin
                if (lcr_wr && brk_bit)       state_nx = LM_BREAK;
                else if (mcr_wr && loop_bit) state_nx = LM_LOOP;
            end
            LM_BREAK: begin
                if (lcr_wr && !brk_bit)      state_nx = LM_NORMAL;
                else if (mcr_wr && loop_bit) state_nx = LM_LOOP_BRK;
            end
            LM_LOOP: begin
                if (lcr_wr && brk_bit)        state_nx = LM_LOOP_BRK;
                else if (mcr_wr && !loop_bit) state_nx = LM_NORMAL;
            end
            LM_LOOP_BRK: begin
                if (lcr_wr && !brk_bit)       state_nx = LM_LOOP;
                else if (mcr_wr && !loop_bit) state_nx = LM_BREAK;
            end
            default: state_nx = LM_NORMAL;
        endcase
    end

    assign mode = state;

    // R2
    brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_wr && brk_bit) |=> (state == LM_BREAK || state == LM_LOOP_BRK));

    // R6
    loop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_wr && loop_bit) |=> (state == LM_LOOP || state == LM_LOOP_BRK));
endmodule

// File: rtl/ucl_pin_mux.sv
module ucl_pin_mux (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ucl_pkg::line_mode_e  mode,
    input  logic [3:0]           mctl,
    input  logic                 tx_serial_in,
    input  logic                 rx_pin,
    input  logic                 cts_n,
    input  logic                 dsr_n,
    input  logic                 ri_n,
    input  logic                 dcd_n,
    output logic                 tx_pin,
    output logic                 rx_to_rcv,
    output logic                 dtr_n,
    output logic                 rts_n,
    output logic                 op1_n,
    output logic                 op2_n,
    output logic                 cts_st,
    output logic                 dsr_st,
    output logic                 ri_st,
    output logic                 dcd_st
);
    import ucl_pkg::*;

    logic looped;

    always_comb begin
        looped = 1'b0;
        tx_pin = tx_serial_in;
        unique case (mode)
            LM_NORMAL:   begin looped = 1'b0; tx_pin = tx_serial_in; end
            LM_BREAK:    begin looped = 1'b0; tx_pin = 1'b0;         end
            LM_LOOP:     begin looped = 1'b1; tx_pin = 1'b1;         end
            LM_LOOP_BRK: begin looped = 1'b1; tx_pin = 1'b1;         end
            default:     begin looped = 1'b0; tx_pin = tx_serial_in; end
        endcase
    end

    always_comb begin
        if (looped) begin
            rx_to_rcv = tx_serial_in;
            {op2_n, op1_n, rts_n, dtr_n} = 4'b1111;
            dsr_st = mctl[DTR_BIT];
            cts_st = mctl[RTS_BIT];
            ri_st  = mctl[OP1_BIT];
            dcd_st = mctl[OP2_BIT];
        end else begin
            rx_to_rcv = rx_pin;
            dtr_n  = ~mctl[DTR_BIT];
            rts_n  = ~mctl[RTS_BIT];
            op1_n  = ~mctl[OP1_BIT];
            op2_n  = ~mctl[OP2_BIT];
            cts_st = ~cts_n;
            dsr_st = ~dsr_n;
            ri_st  = ~ri_n;
            dcd_st = ~dcd_n;
        end
    end

    // R2
    brk_tx_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_BREAK) |-> !tx_pin);

    // R6
    loop_tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_LOOP || mode == LM_LOOP_BRK) |-> (tx_pin && rx_to_rcv == tx_serial_in));

    // R7
    loop_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_LOOP || mode == LM_LOOP_BRK) |-> (dtr_n && rts_n && op1_n && op2_n));
endmodule

// File: rtl/uart_line_ctrl.sv
module uart_line_ctrl #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int LCR_ADDR = 3,
    parameter int MCR_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tx_serial_in,
    input  logic              rx_pin,
    output logic              tx_pin,
    output logic              rx_to_rcv,
    output logic              div_access,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              op1_n,
    output logic              op2_n,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              cts_st,
    output logic              dsr_st,
    output logic              ri_st,
    output logic              dcd_st
);
    import ucl_pkg::*;

    logic [DATA_W-1:0] lcr_q, mcr_q;
    logic              lcr_wr, mcr_wr;
    line_mode_e        mode;

    ucl_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LCR_ADDR(LCR_ADDR), .MCR_ADDR(MCR_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_data(rd_data), .lcr_q(lcr_q), .mcr_q(mcr_q),
        .lcr_wr(lcr_wr), .mcr_wr(mcr_wr)
    );

    ucl_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .lcr_wr(lcr_wr), .mcr_wr(mcr_wr),
        .brk_bit(wdata[BRK_BIT]), .loop_bit(wdata[LOOP_BIT]), .mode(mode)
    );

    ucl_pin_mux u_mux (
        .clk(clk), .rst_n(rst_n), .mode(mode), .mctl(mcr_q[3:0]),
        .tx_serial_in(tx_serial_in), .rx_pin(rx_pin),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .tx_pin(tx_pin), .rx_to_rcv(rx_to_rcv),
        .dtr_n(dtr_n), .rts_n(rts_n), .op1_n(op1_n), .op2_n(op2_n),
        .cts_st(cts_st), .dsr_st(dsr_st), .ri_st(ri_st), .dcd_st(dcd_st)
    );

    assign div_access = lcr_q[DIV_BIT];

    // R3
    div_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_wr |=> (div_access == $past(wdata[DIV_BIT])));

    // R4
    dtr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_wr && !wdata[LOOP_BIT]) |=> (dtr_n == !$past(wdata[DTR_BIT])));

    // R8
    mode_regs_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == LM_LOOP_BRK) == (lcr_q[BRK_BIT] && mcr_q[LOOP_BIT])));
endmodule

// File: tb/uart_line_ctrl_test.sv
module uart_line_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       tx_serial_in = 1'b1, rx_pin = 1'b1;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic [7:0] rd_data;
    logic       tx_pin, rx_to_rcv, div_access, dtr_n, rts_n, op1_n, op2_n;
    logic       cts_st, dsr_st, ri_st, dcd_st;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    uart_line_ctrl uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_data(rd_data), .tx_serial_in(tx_serial_in), .rx_pin(rx_pin),
        .tx_pin(tx_pin), .rx_to_rcv(rx_to_rcv), .div_access(div_access),
        .dtr_n(dtr_n), .rts_n(rts_n), .op1_n(op1_n), .op2_n(op2_n),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .cts_st(cts_st), .dsr_st(dsr_st), .ri_st(ri_st), .dcd_st(dcd_st)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk); addr = a; #1;
        check(req, rd_data, exp);
    endtask

    task automatic t_reset;
        tx_serial_in = 1'b0; #1;
        check("R1 tx follows", tx_pin, 1'b0);
        tx_serial_in = 1'b1; #1;
        check("R1 tx follows", tx_pin, 1'b1);
        check("R1 div", div_access, 1'b0);
        check("R1 modem pins", {dtr_n, rts_n, op1_n, op2_n}, 4'hF);
        rd_check("R1 lcr", 3'd3, 8'h00);
        rd_check("R1 mcr", 3'd4, 8'h00);
    endtask

    task automatic t_break;
        wr(3'd3, 8'h43);
        tx_serial_in = 1'b1; #1;
        check("R2 break low", tx_pin, 1'b0);
        wr(3'd3, 8'h03);
        #1; check("R2 break released", tx_pin, 1'b1);
        tx_serial_in = 1'b0; #1;
        check("R2 follows after", tx_pin, 1'b0);
        tx_serial_in = 1'b1;
    endtask

    task automatic t_div;
        wr(3'd3, 8'h83);
        check("R3 div set", div_access, 1'b1);
        wr(3'd3, 8'h03);
        check("R3 div clear", div_access, 1'b0);
        wr(3'd3, 8'hA5);
        rd_check("R10 lcr readback", 3'd3, 8'hA5);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_modem;
        wr(3'd4, 8'h05);
        check("R4 pins 0101", {op2_n, op1_n, rts_n, dtr_n}, 4'b1010);
        wr(3'd4, 8'h0A);
        check("R4 pins 1010", {op2_n, op1_n, rts_n, dtr_n}, 4'b0101);
        wr(3'd4, 8'hEF);
        rd_check("R5 unused zero", 3'd4, 8'h0F);
        check("R4 all on", {op2_n, op1_n, rts_n, dtr_n}, 4'b0000);
    endtask

    task automatic t_normal_status;
        wr(3'd4, 8'h00);
        rx_pin = 1'b0; #1;
        check("R9 rx pass", rx_to_rcv, 1'b0);
        rx_pin = 1'b1; #1;
        check("R9 rx pass", rx_to_rcv, 1'b1);
        {cts_n, dsr_n, ri_n, dcd_n} = 4'b0110; #1;
        check("R9 status", {cts_st, dsr_st, ri_st, dcd_st}, 4'b1001);
    endtask

    task automatic t_loop;
        wr(3'd4, 8'h15);
        rd_check("R5 loop readback", 3'd4, 8'h15);
        tx_serial_in = 1'b0; rx_pin = 1'b1; #1;
        check("R6 tx idle", tx_pin, 1'b1);
        check("R6 rx from tx", rx_to_rcv, 1'b0);
        tx_serial_in = 1'b1; rx_pin = 1'b0; #1;
        check("R6 rx pin ignored", rx_to_rcv, 1'b1);
        check("R7 pins idle", {dtr_n, rts_n, op1_n, op2_n}, 4'hF);
        {cts_n, dsr_n, ri_n, dcd_n} = 4'b0000; #1;
        check("R7 status from reg", {cts_st, dsr_st, ri_st, dcd_st}, 4'b0110);
        wr(3'd4, 8'h1A);
        check("R7 status from reg", {cts_st, dsr_st, ri_st, dcd_st}, 4'b1001);
        {cts_n, dsr_n, ri_n, dcd_n} = 4'b1111;
    endtask

    task automatic t_loop_break;
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h40);
        wr(3'd4, 8'h10);
        tx_serial_in = 1'b1; rx_pin = 1'b0; #1;
        check("R8 tx idle", tx_pin, 1'b1);
        check("R8 rx path", rx_to_rcv, 1'b1);
        tx_serial_in = 1'b0; rx_pin = 1'b1; #1;
        check("R8 rx path", rx_to_rcv, 1'b0);
        check("R8 tx idle", tx_pin, 1'b1);
        wr(3'd4, 8'h00);
        tx_serial_in = 1'b1; #1;
        check("R2 break after loop", tx_pin, 1'b0);
        wr(3'd3, 8'h00);
        #1; check("R2 cleared", tx_pin, 1'b1);
    endtask

    task automatic t_other_addr;
        wr(3'd3, 8'h1B);
        wr(3'd4, 8'h03);
        wr(3'd2, 8'hFF);
        wr(3'd7, 8'h00);
        rd_check("R10 other reads 0", 3'd2, 8'h00);
        rd_check("R10 lcr untouched", 3'd3, 8'h1B);
        rd_check("R10 mcr untouched", 3'd4, 8'h03);
    endtask

    initial begin
        #2_000_000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_break();
        t_div();
        t_modem();
        t_normal_status();
        t_loop();
        t_loop_break();
        t_other_addr();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule